// File: doc/BRIEF.md
# Receive filter and ring writer

This block takes an incoming Ethernet frame as a byte stream with start-of-frame and end-of-frame markers. It decides whether to keep the frame from three mode bits, the station address and a 64-bit multicast hash table. A kept frame goes into an internal packet memory that is organised as 256-byte pages and used as a ring between a start page and a stop page. A 4-byte header goes in front of the frame. When the frame is complete, the current page pointer moves past it and a one-cycle completion strobe is raised.

The ring limits, the boundary page, the mode bits and the address tables come in as inputs from the host-side register logic. The host reads the memory through a separate read port. The host can also load the current page pointer while no frame is in progress. Before accepting a frame, the block checks that the controller is running and that there is enough free space between the current page and the boundary page. It advertises the result on `rxReady`.

Top module: `rx_ring_filter`

## Requirements
- R1: With `modePromisc` high, every frame of at least 6 bytes is kept, whatever its destination.
- R2: A destination of six 0xFF bytes is kept only when `modeBcast` is high.
- R3: Any other destination whose first byte has bit 0 set is kept only when `modeMcast` is high and `mcastTable[idx]` is 1. `idx` is bits 31:26 of a CRC-32 register that starts at all ones. Each of the six destination bytes is fed into this register least significant bit first, using polynomial 0x04C11DB7 in shift-left form.
- R4: A destination with bit 0 of the first byte clear is kept only when all six bytes equal `stationAddr`, with byte 0 in bits 7:0. A dropped frame, or one ending before its sixth byte, writes no header, leaves `curPage` unchanged and raises no `rxDone`.
- R5: A kept frame shorter than 60 bytes is stored padded with zero bytes up to 60 bytes.
- R6: The header occupies bytes 0 to 3 of page `curPage`. Byte 0 is the status (0x01, or 0x21 when bit 0 of the first destination byte is set). Byte 1 is the next page. Bytes 2 and 3 are the low and high bytes of the stored length plus 4.
- R7: The next page is `curPage + ceil((len+8)/256)`, where `len` is the stored length. When this value is at or above `stopPage`, `stopPage - startPage` is subtracted from it.
- R8: Frame byte k is stored at `curPage*256 + 4 + k`. When the address reaches `stopPage*256`, it continues at `startPage*256`.
- R9: `rxReady` is low, and a frame that starts while it is low is ignored, in either of two cases: when `stopped` is high, or when the free space is below 1518 bytes. Free space is 256×(`bndPage`−`curPage`) if `curPage`<`bndPage`, and otherwise 256×((`stopPage`−`startPage`)−(`curPage`−`bndPage`)).
- R10: For a kept frame of n bytes, `curPage` takes the next page value and `rxDone` pulses high for exactly one cycle. Both happen max(60−n,0)+5 clock edges after the edge that takes the last byte.
- R11: Reset clears `curPage` and `rxDone`. While idle, `curWrEn` loads `curWrData` into `curPage` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Byte strobe of the incoming stream |
| rxSof | input | 1 | Marks the first byte of a frame |
| rxEof | input | 1 | Marks the last byte of a frame |
| rxByte | input | 8 | Frame byte |
| modePromisc | input | 1 | Keep all frames |
| modeBcast | input | 1 | Allow broadcast frames |
| modeMcast | input | 1 | Allow hashed multicast frames |
| stopped | input | 1 | Controller stopped; refuse frames |
| stationAddr | input | 48 | Station address, byte 0 in bits 7:0 |
| mcastTable | input | 64 | Multicast hash table, one bit per index |
| startPage | input | 8 | First page of the ring |
| stopPage | input | 8 | Page after the last page of the ring |
| bndPage | input | 8 | Boundary page held by the host |
| curWrEn | input | 1 | Load the current page pointer |
| curWrData | input | 8 | Value loaded by curWrEn |
| rdAddr | input | ADDR_W | Packet memory read address |
| rdData | output | 8 | Read data, one cycle after rdAddr |
| rxReady | output | 1 | Idle, running and enough free space |
| curPage | output | 8 | Current page pointer |
| rxDone | output | 1 | One-cycle strobe when a frame is committed |

## Verification
The accept decision has no direct output. It becomes visible only when `rxDone` rises, which happens max(60−n,0)+5 edges after the edge that takes the last byte. The bench counts falling edges from the last byte until the strobe appears and compares that count with the formula for each frame length. For dropped frames, it watches the strobe for 80 cycles, which is well beyond the longest possible latency. `curPage` is sampled on the falling edge right after the strobe. The read port has one register, so each memory check samples `rdData` one falling edge after `rdAddr` is driven.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {S_IDLE, S_DEST, S_BODY, S_SKIP, S_PAD, S_HDR} rxfState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       frameStart;
    logic       byteWr;
    logic       padWr;
    logic       hdrWr;
    logic [1:0] hdrSel;
    logic       commit;
  } rxfStrobe_t;

  // One byte of the hash CRC: data LSB first, shift-left form.
  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxSof,
  input  logic       rxEof,
  input  logic       ready,
  input  logic       destLast,
  input  logic       accept,
  input  logic       padDone,
  output rxfStrobe_t stb,
  output logic       idle
);
  rxfState_e state, stateNx;
  logic [1:0] hdrCnt;

  always_comb begin
    stb     = '0;
    stateNx = state;
    unique case (state)
      S_IDLE: if (rxValid && rxSof) begin
        if (ready) begin
          stb.frameStart = 1'b1;
          stb.byteWr     = 1'b1;
          stateNx        = rxEof ? S_IDLE : S_DEST;
        end else begin
          stateNx = rxEof ? S_IDLE : S_SKIP;
        end
      end
      S_DEST: if (rxValid) begin
        stb.byteWr = 1'b1;
        if (destLast) begin
          if (accept) stateNx = rxEof ? S_PAD : S_BODY;
          else        stateNx = rxEof ? S_IDLE : S_SKIP;
        end else if (rxEof) begin
          stateNx = S_IDLE;
        end
      end
      S_BODY: if (rxValid) begin
        stb.byteWr = 1'b1;
        if (rxEof) stateNx = S_PAD;
      end
      S_SKIP: if (rxValid && rxEof) stateNx = S_IDLE;
      S_PAD: begin
        if (padDone) stateNx = S_HDR;
        else         stb.padWr = 1'b1;
      end
      S_HDR: begin
        stb.hdrWr  = 1'b1;
        stb.hdrSel = hdrCnt;
        if (hdrCnt == 2'd3) begin
          stb.commit = 1'b1;
          stateNx    = S_IDLE;
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      hdrCnt <= '0;
    end else begin
      state  <= stateNx;
      hdrCnt <= (state == S_HDR) ? hdrCnt + 2'd1 : 2'd0;
    end
  end

  assign idle = (state == S_IDLE);

  // R9: a refused frame never enters the capture states
  p_refuse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && rxValid && rxSof && !ready) |=> (state != S_DEST && state != S_BODY));
  // R6: the four header bytes go out back to back
  p_hdr_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HDR && hdrCnt != 2'd3) |=> (state == S_HDR));
endmodule

// File: rtl/rxf_dpath.sv
module rxf_dpath
  import rxf_pkg::*;
#(
  parameter int MEM_PAGES = 8,
  parameter int MIN_FRAME = 60,
  parameter int MIN_FREE  = 1518,
  parameter int LEN_W     = 12,
  localparam int ADDR_W   = 8 + $clog2(MEM_PAGES),
  localparam int MEM_BYTES = MEM_PAGES * 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxfStrobe_t        stb,
  input  logic              idle,
  input  logic [7:0]        rxByte,
  input  logic              modePromisc,
  input  logic              modeBcast,
  input  logic              modeMcast,
  input  logic [47:0]       stationAddr,
  input  logic [63:0]       mcastTable,
  input  logic              stopped,
  input  logic [7:0]        startPage,
  input  logic [7:0]        stopPage,
  input  logic [7:0]        bndPage,
  input  logic              curWrEn,
  input  logic [7:0]        curWrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              ready,
  output logic              destLast,
  output logic              accept,
  output logic              padDone,
  output logic [7:0]        curPage,
  output logic              rxDone
);
  logic [7:0]       mem [MEM_BYTES];
  logic [LEN_W-1:0] cnt;
  logic [15:0]      dataAddr, curBase, srcAddr, addrInc, addrNext, wrAddrL;
  logic             onesReg, matchReg, groupReg;
  logic [31:0]      crcReg, crcNow;
  logic             onesNow, matchNow;
  logic [7:0]       stnByte, wrByte, status, nextPage;
  logic [LEN_W-1:0] total;
  logic [LEN_W:0]   roundUp;
  logic [8:0]       pagesUsed, nextSum, ringPages;
  logic signed [9:0]  availPages;
  logic signed [17:0] availBytes;
  logic             wrEn, destWr;

  // Destination filter, evaluated with the byte on the bus
  assign stnByte  = 8'(stationAddr >> {cnt[2:0], 3'b000});
  assign onesNow  = onesReg & (rxByte == 8'hFF);
  assign matchNow = matchReg & (rxByte == stnByte);
  assign crcNow   = crcStep(crcReg, rxByte);
  assign destLast = (cnt == LEN_W'(5));
  assign accept   = modePromisc |
                    (onesNow ? modeBcast : (groupReg ? (modeMcast & mcastTable[crcNow[31:26]]) : matchNow));
  assign destWr   = stb.byteWr && !stb.frameStart && (cnt < LEN_W'(6));

  always_ff @(posedge clk) begin
    if (stb.frameStart) begin
      onesReg  <= (rxByte == 8'hFF);
      matchReg <= (rxByte == stationAddr[7:0]);
      crcReg   <= crcStep(32'hFFFF_FFFF, rxByte);
      groupReg <= rxByte[0];
    end else if (destWr) begin
      onesReg  <= onesNow;
      matchReg <= matchNow;
      crcReg   <= crcNow;
    end
  end

  // Byte counter and ring write address
  assign padDone  = (cnt >= LEN_W'(MIN_FRAME));
  assign curBase  = {curPage, 8'h00};
  assign srcAddr  = stb.frameStart ? curBase + 16'd4 : dataAddr;
  assign addrInc  = srcAddr + 16'd1;
  assign addrNext = (addrInc == {stopPage, 8'h00}) ? {startPage, 8'h00} : addrInc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      dataAddr <= '0;
    end else if (stb.frameStart) begin
      cnt      <= LEN_W'(1);
      dataAddr <= addrNext;
    end else if (stb.byteWr || stb.padWr) begin
      cnt      <= cnt + LEN_W'(1);
      dataAddr <= addrNext;
    end
  end

  // Header fields and next page
  assign total     = cnt + LEN_W'(4);
  assign roundUp   = {1'b0, total} + (LEN_W+1)'(259);
  assign pagesUsed = 9'(roundUp >> 8);
  assign nextSum   = {1'b0, curPage} + pagesUsed;
  assign ringPages = {1'b0, stopPage} - {1'b0, startPage};
  assign nextPage  = (nextSum >= {1'b0, stopPage}) ? 8'(nextSum - ringPages) : nextSum[7:0];
  assign status    = groupReg ? 8'h21 : 8'h01;

  always_comb begin
    wrAddrL = srcAddr;
    wrByte  = stb.padWr ? 8'h00 : rxByte;
    if (stb.hdrWr) begin
      wrAddrL = curBase + {14'd0, stb.hdrSel};
      unique case (stb.hdrSel)
        2'd0:    wrByte = status;
        2'd1:    wrByte = nextPage;
        2'd2:    wrByte = total[7:0];
        default: wrByte = 8'(total >> 8);
      endcase
    end
  end
  assign wrEn = stb.byteWr | stb.padWr | stb.hdrWr;

  always_ff @(posedge clk) begin
    if (wrEn) mem[ADDR_W'(wrAddrL)] <= wrByte;
    rdData <= mem[rdAddr];
  end

  // Free space against the boundary page
  always_comb begin
    if (curPage < bndPage)
      availPages = $signed({2'b00, bndPage}) - $signed({2'b00, curPage});
    else
      availPages = ($signed({2'b00, stopPage}) - $signed({2'b00, startPage}))
                 - ($signed({2'b00, curPage}) - $signed({2'b00, bndPage}));
  end
  assign availBytes = $signed({availPages, 8'h00});
  assign ready      = !stopped && (availBytes >= $signed(18'(MIN_FREE)));

  // Current page pointer and completion strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxDone <= stb.commit;
      if (stb.commit)             curPage <= nextPage;
      else if (curWrEn && idle)   curPage <= curWrData;
    end
  end

  // R10: completion is a single-cycle strobe
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN) rxDone |=> !rxDone);
  // R5: header only after the frame has been padded to the minimum
  p_pad_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.hdrWr |-> (cnt >= LEN_W'(MIN_FRAME)));
  // R7: the pointer stays inside the ring after a commit
  p_ring_cur_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && startPage < stopPage && curPage >= startPage && curPage < stopPage)
      |=> (curPage >= startPage && curPage < stopPage));
  // R8: payload writes never land outside the ring
  p_wr_in_ring_r8: assert property (@(posedge clk) disable iff (!rstN)
    (((stb.byteWr && !stb.frameStart) || stb.padWr) && curPage >= startPage && curPage < stopPage)
      |-> (dataAddr >= {startPage, 8'h00} && dataAddr < {stopPage, 8'h00}));
endmodule

// File: rtl/rx_ring_filter.sv
module rx_ring_filter
  import rxf_pkg::*;
#(
  parameter int MEM_PAGES = 8,
  parameter int MIN_FRAME = 60,
  parameter int MIN_FREE  = 1518,
  parameter int LEN_W     = 12,
  localparam int ADDR_W   = 8 + $clog2(MEM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxSof,
  input  logic              rxEof,
  input  logic [7:0]        rxByte,
  input  logic              modePromisc,
  input  logic              modeBcast,
  input  logic              modeMcast,
  input  logic              stopped,
  input  logic [47:0]       stationAddr,
  input  logic [63:0]       mcastTable,
  input  logic [7:0]        startPage,
  input  logic [7:0]        stopPage,
  input  logic [7:0]        bndPage,
  input  logic              curWrEn,
  input  logic [7:0]        curWrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rxReady,
  output logic [7:0]        curPage,
  output logic              rxDone
);
  rxfStrobe_t stb;
  logic idle, ready, destLast, accept, padDone;

  rxf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .ready(ready), .destLast(destLast), .accept(accept), .padDone(padDone),
    .stb(stb), .idle(idle)
  );

  rxf_dpath #(.MEM_PAGES(MEM_PAGES), .MIN_FRAME(MIN_FRAME), .MIN_FREE(MIN_FREE), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .idle(idle), .rxByte(rxByte),
    .modePromisc(modePromisc), .modeBcast(modeBcast), .modeMcast(modeMcast),
    .stationAddr(stationAddr), .mcastTable(mcastTable), .stopped(stopped),
    .startPage(startPage), .stopPage(stopPage), .bndPage(bndPage),
    .curWrEn(curWrEn), .curWrData(curWrData), .rdAddr(rdAddr), .rdData(rdData),
    .ready(ready), .destLast(destLast), .accept(accept), .padDone(padDone),
    .curPage(curPage), .rxDone(rxDone)
  );

  assign rxReady = idle & ready;
endmodule

// File: tb/sim_rx_ring_filter.sv
module sim_rx_ring_filter;
  localparam int CLK_P = 10;
  localparam logic [47:0] STN = 48'h5634_1200_5452;
  localparam logic [47:0] MCA = 48'h2A00_005E_0001;
  // {kind[1:0], len[11:0], promisc, bcast, mcast, hit, exp, 5'd0}
  // kind: 0 station match, 1 station mismatch, 2 broadcast, 3 multicast
  localparam logic [23:0] VEC [11] = '{
    {2'd0, 12'd64,  5'b00001, 5'd0},  // R4 match kept
    {2'd1, 12'd64,  5'b00000, 5'd0},  // R4 mismatch dropped
    {2'd1, 12'd64,  5'b10001, 5'd0},  // R1 promisc keeps mismatch
    {2'd2, 12'd100, 5'b01001, 5'd0},  // R2 broadcast allowed
    {2'd2, 12'd100, 5'b00000, 5'd0},  // R2 broadcast refused
    {2'd3, 12'd70,  5'b00111, 5'd0},  // R3 hashed hit
    {2'd3, 12'd70,  5'b00100, 5'd0},  // R3 hashed miss
    {2'd3, 12'd70,  5'b00010, 5'd0},  // R3 multicast disabled
    {2'd0, 12'd20,  5'b00001, 5'd0},  // R5 short frame padded
    {2'd0, 12'd300, 5'b00001, 5'd0},  // R7 two pages
    {2'd2, 12'd61,  5'b11001, 5'd0}   // R2 broadcast with promisc
  };

  logic clk = 0, rstN = 0;
  logic rxValid = 0, rxSof = 0, rxEof = 0;
  logic [7:0] rxByte = 0;
  logic modePromisc = 0, modeBcast = 0, modeMcast = 0, stopped = 0;
  logic [63:0] mcastTable = 0;
  logic [7:0] startPage = 8'd1, stopPage = 8'd8, bndPage = 8'd0;
  logic curWrEn = 0;
  logic [7:0] curWrData = 0;
  logic [10:0] rdAddr = 0;
  logic [7:0] rdData, curPage;
  logic rxReady, rxDone;
  logic [7:0] fb [0:2047];
  int nChk = 0, nBad = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_ring_filter u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxByte(rxByte),
    .modePromisc(modePromisc), .modeBcast(modeBcast), .modeMcast(modeMcast), .stopped(stopped),
    .stationAddr(STN), .mcastTable(mcastTable), .startPage(startPage), .stopPage(stopPage),
    .bndPage(bndPage), .curWrEn(curWrEn), .curWrData(curWrData), .rdAddr(rdAddr),
    .rdData(rdData), .rxReady(rxReady), .curPage(curPage), .rxDone(rxDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] hashIdx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      logic fbit = c[31] ^ d[b];
      c = c << 1;
      if (fbit) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  function automatic int addrOf(input int base, input int k);
    int a = base + 4 + k;
    if (a >= int'(stopPage) * 256) a -= (int'(stopPage) - int'(startPage)) * 256;
    return a % 2048;
  endfunction

  function automatic int nextOf(input int cur, input int n);
    int len = (n < 60) ? 60 : n;
    int nx = cur + (len + 4 + 4 + 255) / 256;
    if (nx >= int'(stopPage)) nx -= int'(stopPage) - int'(startPage);
    return nx;
  endfunction

  task automatic buildFrame(input int kind, input int n);
    logic [47:0] d;
    case (kind)
      0: d = STN;
      1: d = STN ^ 48'h0100_0000_0000;
      2: d = 48'hFFFF_FFFF_FFFF;
      default: d = MCA;
    endcase
    for (int i = 0; i < n; i++) fb[i] = (i < 6) ? d[8*i +: 8] : 8'(i * 7 + 3);
  endtask

  task automatic sendFrame(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1; rxSof = (i == 0); rxEof = (i == n - 1); rxByte = fb[i];
    end
  endtask

  // Counts falling edges after the last byte until rxDone, up to limit.
  task automatic waitDone(input int limit, output int lat, output bit seen);
    lat = 0; seen = 0;
    while (lat < limit && !seen) begin
      @(negedge clk);
      if (lat == 0) begin rxValid = 0; rxSof = 0; rxEof = 0; end
      lat++;
      if (rxDone) seen = 1;
    end
  endtask

  task automatic rdMem(input int a, output logic [7:0] d);
    @(negedge clk); rdAddr = 11'(a);
    @(negedge clk); d = rdData;
  endtask

  task automatic setCur(input logic [7:0] v);
    @(negedge clk); curWrEn = 1; curWrData = v;
    @(negedge clk); curWrEn = 0;
    chk("R11 pointer load", 32'(curPage), 32'(v));
  endtask

  // Sends a frame expected to be kept and checks commit, header and payload.
  task automatic keptFrame(input string tag, input int n);
    int lat, oldCur, base, p;
    bit seen;
    logic [7:0] d;
    oldCur = int'(curPage);
    base = oldCur * 256;
    p = (n < 60) ? 60 - n : 0;
    sendFrame(n);
    waitDone(200, lat, seen);
    chk({tag, " kept"}, 32'(seen), 32'd1);
    // last-byte edge plus p pad edges, one move and four header edges
    chk("R10 done latency", 32'(lat), 32'(p + 6));
    chk("R7 next page", 32'(curPage), 32'(nextOf(oldCur, n)));
    @(negedge clk);
    chk("R10 single pulse", 32'(rxDone), 32'd0);
    rdMem(base % 2048, d);     chk("R6 status", 32'(d), fb[0][0] ? 32'h21 : 32'h01);
    rdMem(base % 2048 + 1, d); chk("R6 next", 32'(d), 32'(nextOf(oldCur, n)));
    rdMem(base % 2048 + 2, d); chk("R6 len lo", 32'(d), 32'(((n < 60 ? 60 : n) + 4) % 256));
    rdMem(base % 2048 + 3, d); chk("R6 len hi", 32'(d), 32'(((n < 60 ? 60 : n) + 4) / 256));
    rdMem(addrOf(base, n - 1), d); chk("R8 last byte", 32'(d), 32'(fb[n-1]));
    if (n < 60) begin
      rdMem(addrOf(base, 59), d); chk("R5 pad zero", 32'(d), 32'd0);
    end
  endtask

  task automatic droppedFrame(input string tag, input int n);
    int lat, oldCur;
    bit seen;
    oldCur = int'(curPage);
    sendFrame(n);
    waitDone(80, lat, seen);
    chk({tag, " no done"}, 32'(seen), 32'd0);
    chk({tag, " pointer held"}, 32'(curPage), 32'(oldCur));
  endtask

  initial begin
    #(CLK_P * 150000);
    nBad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R11 reset pointer", 32'(curPage), 32'd0);
    chk("R11 reset done", 32'(rxDone), 32'd0);
    chk("R9 ready after reset", 32'(rxReady), 32'd1);

    setCur(8'd1);
    for (int v = 0; v < 11; v++) begin
      int kind, len;
      bit pr, bc, mc, hit, ex;
      string tag;
      kind = int'(VEC[v][23:22]); len = int'(VEC[v][21:10]);
      {pr, bc, mc, hit, ex} = VEC[v][9:5];
      tag = (kind == 2) ? "R2" : (kind == 3) ? "R3" : (pr ? "R1" : "R4");
      @(negedge clk);
      modePromisc = pr; modeBcast = bc; modeMcast = mc;
      mcastTable = (kind == 3) ? (hit ? (64'd1 << hashIdx(MCA)) : ~(64'd1 << hashIdx(MCA))) : 64'd0;
      bndPage = curPage;
      buildFrame(kind, len);
      if (ex) keptFrame(tag, len);
      else    droppedFrame(tag, len);
    end

    // R4 runt frame ending before the sixth byte
    @(negedge clk); modePromisc = 1; modeBcast = 0; modeMcast = 0; bndPage = curPage;
    buildFrame(0, 4);
    droppedFrame("R4 runt", 4);
    modePromisc = 0;

    // R8 payload wraps from the stop page to the start page
    setCur(8'd7);
    @(negedge clk); bndPage = 8'd7;
    buildFrame(0, 300);
    keptFrame("R8", 300);
    begin
      logic [7:0] d;
      rdMem(256, d);      chk("R8 wrapped byte", 32'(d), 32'(fb[252]));
      rdMem(256 + 47, d); chk("R8 wrapped tail", 32'(d), 32'(fb[299]));
    end
    chk("R7 wrapped next", 32'(curPage), 32'd2);

    // R9 stopped controller
    @(negedge clk); stopped = 1; bndPage = curPage;
    @(negedge clk);
    chk("R9 ready when stopped", 32'(rxReady), 32'd0);
    buildFrame(0, 64);
    droppedFrame("R9 stopped", 64);
    stopped = 0;

    // R9 free space: 5 pages refused, 6 pages allowed
    setCur(8'd2);
    @(negedge clk); bndPage = 8'd7;
    @(negedge clk);
    chk("R9 five pages free", 32'(rxReady), 32'd0);
    droppedFrame("R9 full", 64);
    setCur(8'd1);
    @(negedge clk);
    chk("R9 six pages free", 32'(rxReady), 32'd1);
    keptFrame("R9", 64);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule